// File: doc/BRIEF.md
# CAN Controller Mode, Command and Interrupt Register File

This block is the software-facing register file of a CAN controller core. A host reaches it through a simple 32-bit word-addressed bus with a one-cycle select/write qualifier and a combinational read path. It holds the operating-mode word, turns command writes into single-cycle strobes for the protocol engine, mirrors the engine's status levels, latches interrupt events into write-one-to-clear flags gated by an enable mask, and keeps the transmit and receive error counts.

The protocol engine, bit timing and message storage sit outside. The engine reports to this block through event pulses, status levels and a counter update port. It takes back the mode bits and the command strobes. The level interrupt output is high whenever any flag is set.

Word addresses: 0 mode, 1 command, 2 status, 3 interrupt flags, 4 interrupt enable, 5 error counts. Other addresses read as zero and ignore writes.

Top module: `can_ctrl_regs`

## Requirements
- R1: After reset the mode word reads 0x01 (reset mode on), status reads 0x3C, flags, enable and error counts read 0, and `irq` and all strobes are low.
- R2: Mode bit 0 (reset mode), bit 1 (listen-only) and bit 2 (loopback) take any written value. Each shows on readback and on its mode pin after the write edge, so leaving reset mode is visible on the very next read.
- R3: Mode bit 3 (1 = single filter) and bit 4 (sleep) take a write only when the reset-mode bit held before that write is 1. Otherwise they keep their value.
- R4: A write to the command word raises `cmd_strobe[i]` for exactly the one cycle after the write edge, for each written bit i. The bits are: 0 transmit, 1 abort, 2 release receive buffer, 3 clear overrun, 4 self-receive, 5 bus-off.
- R5: The command word always reads back as zero.
- R6: Status bits 0 and 2 to 7 follow `eng_sts` one edge later. Bit 1 (data overrun) is sticky: it is set by `eng_sts[1]` and held after that input falls.
- R7: A command write with bit 3 set clears status bit 1. If an overrun is reported on the same edge, the bit stays set.
- R8: An `ev_irq[i]` pulse sets flag i only when enable bit i is 1. Flag bits are: 0 receive, 1 transmit done, 2 error warning, 3 overrun, 4 wake-up, 5 error passive, 6 arbitration lost, 7 bus error.
- R9: Writing 1 to a flag bit clears it and writing 0 leaves it. When a set event and a clear hit the same flag on one edge, the flag ends set.
- R10: `irq` is high exactly while at least one flag is set.
- R11: The error word holds the transmit count in bits 7:0 and the receive count in bits 23:16. An `err_upd` pulse loads both counts, a write of 0 clears both, and a nonzero write changes neither.
- R12: Writes to the status word and to unmapped addresses change nothing, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access qualifier |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| ev_irq | input | 8 | Interrupt event pulses from the engine |
| eng_sts | input | 8 | Status levels from the engine (bit 1 is an overrun set request) |
| err_upd | input | 1 | Load pulse for the error counts |
| err_tx_in | input | 8 | Transmit error count to load |
| err_rx_in | input | 8 | Receive error count to load |
| irq | output | 1 | Level interrupt |
| mode_reset | output | 1 | Reset mode active |
| mode_listen | output | 1 | Listen-only mode |
| mode_loopback | output | 1 | Loopback mode |
| mode_single_filt | output | 1 | Single acceptance filter selected |
| mode_sleep | output | 1 | Sleep requested |
| cmd_strobe | output | 6 | One-cycle command strobes |

## Verification
Every register updates on the edge that samples a write, an event or an engine input. Readback is combinational, so a result shows at the falling edge after that rising edge. Command strobes are high during the one cycle that follows the write edge and low again one cycle later. The bench drives every stimulus on a falling edge for one full cycle. It reads or samples on the following falling edge, and for strobes it also samples the falling edge after that to confirm the pulse has ended. Simultaneous set/clear cases put both stimuli in the same driven cycle so that they meet on one rising edge.

// File: rtl/can_regs_pkg.sv
package can_regs_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int MODE_W  = 5;
    localparam int CMD_W   = 6;
    localparam int STS_W   = 8;
    localparam int IRQ_W   = 8;
    localparam int CNT_W   = 8;
    localparam int RX_LSB  = 16;

    localparam logic [ADDR_W-1:0] ADR_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CMD  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_STS  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_IRQ  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_IEN  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_ERR  = 3'd5;

    // mode bit positions
    localparam int MB_RESET  = 0;
    localparam int MB_LISTEN = 1;
    localparam int MB_LOOP   = 2;
    localparam int MB_FILT   = 3;
    localparam int MB_SLEEP  = 4;

    localparam int CMD_CLR_OVR = 3;
    localparam int STS_OVR     = 1;

    localparam logic [MODE_W-1:0] MODE_RST_VAL = 5'h01;
    localparam logic [STS_W-1:0]  STS_RST_VAL  = 8'h3C;

    typedef struct packed {
        logic [MODE_W-1:0] bits;
    } mode_st_t;

    typedef struct packed {
        logic [CMD_W-1:0] strobe;
    } cmd_st_t;

    typedef struct packed {
        logic [IRQ_W-1:0] flags;
        logic [IRQ_W-1:0] en;
    } irq_st_t;

    typedef struct packed {
        logic [STS_W-1:0] sts;
        logic [CNT_W-1:0] tx_cnt;
        logic [CNT_W-1:0] rx_cnt;
    } sts_st_t;
endpackage

// File: rtl/can_mode_reg.sv
module can_mode_reg
    import can_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MODE_W-1:0] wdata,
    output logic [MODE_W-1:0] mode
);
    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.bits[MB_RESET]  = wdata[MB_RESET];
            st_d.bits[MB_LISTEN] = wdata[MB_LISTEN];
            st_d.bits[MB_LOOP]   = wdata[MB_LOOP];
            // locked fields: gated by the reset bit held before this write
            if (st_q.bits[MB_RESET]) begin
                st_d.bits[MB_FILT]  = wdata[MB_FILT];
                st_d.bits[MB_SLEEP] = wdata[MB_SLEEP];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bits: MODE_RST_VAL};
        else        st_q <= st_d;
    end

    assign mode = st_q.bits;
endmodule

// File: rtl/can_cmd_strobe.sv
module can_cmd_strobe
    import can_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CMD_W-1:0] wdata,
    output logic [CMD_W-1:0] strobe
);
    cmd_st_t st_d, st_q;

    always_comb begin
        st_d.strobe = we ? wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = st_q.strobe;
endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
    import can_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_flags,
    input  logic             we_en,
    input  logic [IRQ_W-1:0] wdata,
    input  logic [IRQ_W-1:0] ev,
    output logic [IRQ_W-1:0] flags,
    output logic [IRQ_W-1:0] en,
    output logic             irq
);
    irq_st_t st_d, st_q;
    logic [IRQ_W-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = we_flags ? wdata : '0;
        if (we_en) st_d.en = wdata;
        // set after clear: a simultaneous event wins
        st_d.flags = (st_q.flags & ~clr_mask) | (ev & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
    assign en    = st_q.en;
    assign irq   = |st_q.flags;
endmodule

// File: rtl/can_status_unit.sv
module can_status_unit
    import can_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] eng_sts,
    input  logic             clr_ovr,
    input  logic             err_upd,
    input  logic [CNT_W-1:0] err_tx_in,
    input  logic [CNT_W-1:0] err_rx_in,
    input  logic             err_clr,
    output logic [STS_W-1:0] sts,
    output logic [CNT_W-1:0] tx_cnt,
    output logic [CNT_W-1:0] rx_cnt
);
    sts_st_t st_d, st_q;

    always_comb begin
        st_d              = st_q;
        st_d.sts          = eng_sts;
        st_d.sts[STS_OVR] = eng_sts[STS_OVR] | (st_q.sts[STS_OVR] & ~clr_ovr);
        if (err_upd) begin
            st_d.tx_cnt = err_tx_in;
            st_d.rx_cnt = err_rx_in;
        end else if (err_clr) begin
            st_d.tx_cnt = '0;
            st_d.rx_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sts: STS_RST_VAL, tx_cnt: '0, rx_cnt: '0};
        else        st_q <= st_d;
    end

    assign sts    = st_q.sts;
    assign tx_cnt = st_q.tx_cnt;
    assign rx_cnt = st_q.rx_cnt;
endmodule

// File: rtl/can_ctrl_regs.sv
module can_ctrl_regs
    import can_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IRQ_W-1:0]  ev_irq,
    input  logic [STS_W-1:0]  eng_sts,
    input  logic              err_upd,
    input  logic [CNT_W-1:0]  err_tx_in,
    input  logic [CNT_W-1:0]  err_rx_in,
    output logic              irq,
    output logic              mode_reset,
    output logic              mode_listen,
    output logic              mode_loopback,
    output logic              mode_single_filt,
    output logic              mode_sleep,
    output logic [CMD_W-1:0]  cmd_strobe
);
    logic              wr_any;
    logic              we_mode, we_cmd, we_flags, we_en, we_err;
    logic [MODE_W-1:0] mode_word;
    logic [IRQ_W-1:0]  int_flags, int_en;
    logic [STS_W-1:0]  sts_word;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;

    assign wr_any   = bus_sel & bus_wr;
    assign we_mode  = wr_any && (bus_addr == ADR_MODE);
    assign we_cmd   = wr_any && (bus_addr == ADR_CMD);
    assign we_flags = wr_any && (bus_addr == ADR_IRQ);
    assign we_en    = wr_any && (bus_addr == ADR_IEN);
    assign we_err   = wr_any && (bus_addr == ADR_ERR);

    can_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_mode),
        .wdata (bus_wdata[MODE_W-1:0]),
        .mode  (mode_word)
    );

    can_cmd_strobe u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we_cmd),
        .wdata  (bus_wdata[CMD_W-1:0]),
        .strobe (cmd_strobe)
    );

    can_irq_unit u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_flags (we_flags),
        .we_en    (we_en),
        .wdata    (bus_wdata[IRQ_W-1:0]),
        .ev       (ev_irq),
        .flags    (int_flags),
        .en       (int_en),
        .irq      (irq)
    );

    can_status_unit u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .eng_sts   (eng_sts),
        .clr_ovr   (we_cmd & bus_wdata[CMD_CLR_OVR]),
        .err_upd   (err_upd),
        .err_tx_in (err_tx_in),
        .err_rx_in (err_rx_in),
        .err_clr   (we_err && (bus_wdata == '0)),
        .sts       (sts_word),
        .tx_cnt    (tx_cnt),
        .rx_cnt    (rx_cnt)
    );

    assign mode_reset       = mode_word[MB_RESET];
    assign mode_listen      = mode_word[MB_LISTEN];
    assign mode_loopback    = mode_word[MB_LOOP];
    assign mode_single_filt = mode_word[MB_FILT];
    assign mode_sleep       = mode_word[MB_SLEEP];

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_MODE: bus_rdata[MODE_W-1:0] = mode_word;
            ADR_STS:  bus_rdata[STS_W-1:0]  = sts_word;
            ADR_IRQ:  bus_rdata[IRQ_W-1:0]  = int_flags;
            ADR_IEN:  bus_rdata[IRQ_W-1:0]  = int_en;
            ADR_ERR: begin
                bus_rdata[CNT_W-1:0]       = tx_cnt;
                bus_rdata[RX_LSB +: CNT_W] = rx_cnt;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/can_ctrl_regs_chk.sv
module can_ctrl_regs_chk
    import can_regs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CMD_W-1:0]  cmd_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [IRQ_W-1:0]  ev_irq,
    input logic              irq,
    input logic              mode_reset,
    input logic              mode_sleep,
    input logic              mode_single_filt,
    input logic [CMD_W-1:0]  cmd_strobe,
    input logic [IRQ_W-1:0]  int_flags,
    input logic [IRQ_W-1:0]  int_en,
    input logic              sts_ovr
);
    // R4: a strobe only follows a command write carrying the same bits
    p_strobe_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe != '0) |->
            ($past(bus_sel && bus_wr && (bus_addr == ADR_CMD)) && (cmd_strobe == $past(cmd_wdata))));

    // R5: command word reads zero
    p_cmd_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == ADR_CMD)) |-> (bus_rdata == '0));

    // R3: locked mode fields hold while out of reset mode
    p_locked_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_reset) |-> ($stable(mode_sleep) && $stable(mode_single_filt)));

    // R7: overrun status falls only after a clear-overrun command
    p_ovr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_ovr) |->
            $past(bus_sel && bus_wr && (bus_addr == ADR_CMD) && cmd_wdata[CMD_CLR_OVR]));

    // R8: a flag rises only from an enabled event
    p_flag_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_flags & ~$past(int_flags) & ~$past(ev_irq & int_en)) == '0));

    // R10: interrupt rises only after an enabled event
    p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(ev_irq & int_en) != '0));
endmodule

bind can_ctrl_regs can_ctrl_regs_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_sel          (bus_sel),
    .bus_wr           (bus_wr),
    .bus_addr         (bus_addr),
    .cmd_wdata        (bus_wdata[5:0]),
    .bus_rdata        (bus_rdata),
    .ev_irq           (ev_irq),
    .irq              (irq),
    .mode_reset       (mode_reset),
    .mode_sleep       (mode_sleep),
    .mode_single_filt (mode_single_filt),
    .cmd_strobe       (cmd_strobe),
    .int_flags        (int_flags),
    .int_en           (int_en),
    .sts_ovr          (sts_word[1])
);

// File: tb/can_ctrl_regs_test.sv
`timescale 1ns/1ps
module can_ctrl_regs_test;
    localparam logic [2:0] A_MODE = 3'd0, A_CMD = 3'd1, A_STS = 3'd2,
                           A_FLG = 3'd3, A_IEN = 3'd4, A_ERR = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  ev_irq = '0;
    logic [7:0]  eng_sts = 8'h3C;
    logic        err_upd = 1'b0;
    logic [7:0]  err_tx_in = '0, err_rx_in = '0;
    logic        irq, mode_reset, mode_listen, mode_loopback, mode_single_filt, mode_sleep;
    logic [5:0]  cmd_strobe;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    can_ctrl_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_irq(ev_irq), .eng_sts(eng_sts), .err_upd(err_upd),
        .err_tx_in(err_tx_in), .err_rx_in(err_rx_in), .irq(irq),
        .mode_reset(mode_reset), .mode_listen(mode_listen),
        .mode_loopback(mode_loopback), .mode_single_filt(mode_single_filt),
        .mode_sleep(mode_sleep), .cmd_strobe(cmd_strobe)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, req, act, exp);
    endtask

    // one full cycle of stimulus, returns on the falling edge after the sampling edge
    task automatic drive(input logic we, input logic [2:0] a, input logic [31:0] d, input logic [7:0] e);
        @(negedge clk);
        bus_sel = we; bus_wr = we; bus_addr = a; bus_wdata = d; ev_irq = e;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; ev_irq = '0;
    endtask

    task automatic idle();
        drive(1'b0, 3'd0, 32'h0, 8'h0);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [7:0] flag_next(input logic [7:0] f, input logic [7:0] en,
                                             input logic [7:0] clr, input logic [7:0] ev);
        return (f & ~clr) | (ev & en);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] m_flags, m_en;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R1 reset state
        rd(A_MODE, rv); check_eq("R1 mode", rv, 32'h1);
        rd(A_STS, rv);  check_eq("R1 status", rv, 32'h3C);
        rd(A_FLG, rv);  check_eq("R1 flags", rv, 32'h0);
        rd(A_IEN, rv);  check_eq("R1 enable", rv, 32'h0);
        rd(A_ERR, rv);  check_eq("R1 errcnt", rv, 32'h0);
        check_eq("R1 irq/strobe", {25'b0, irq, cmd_strobe}, 32'h0);

        // R2 free mode bits
        drive(1'b1, A_MODE, 32'h7, 8'h0);
        rd(A_MODE, rv); check_eq("R2 mode readback", rv, 32'h7);
        check_eq("R2 pins", {29'b0, mode_loopback, mode_listen, mode_reset}, 32'h7);

        // R3 locked fields
        drive(1'b1, A_MODE, 32'h19, 8'h0);
        rd(A_MODE, rv); check_eq("R3 write in reset mode", rv, 32'h19);
        drive(1'b1, A_MODE, 32'h00, 8'h0);
        rd(A_MODE, rv); check_eq("R3 leave reset with gated clear", rv, 32'h00);
        drive(1'b1, A_MODE, 32'h18, 8'h0);
        rd(A_MODE, rv); check_eq("R3 locked write ignored", rv, 32'h00);
        check_eq("R3 sleep pin", {31'b0, mode_sleep}, 32'h0);
        drive(1'b1, A_MODE, 32'h01, 8'h0);
        drive(1'b1, A_MODE, 32'h1E, 8'h0);
        rd(A_MODE, rv); check_eq("R2 leave reset visible at once", rv, 32'h1E);
        check_eq("R2 reset pin low", {31'b0, mode_reset}, 32'h0);
        drive(1'b1, A_MODE, 32'h06, 8'h0);
        rd(A_MODE, rv); check_eq("R3 sleep/filter held", rv, 32'h1E);
        check_eq("R3 filt pin", {31'b0, mode_single_filt}, 32'h1);

        // R4 strobes
        for (int i = 0; i < 6; i++) begin
            drive(1'b1, A_CMD, 32'(1 << i), 8'h0);
            check_eq("R4 strobe high", {26'b0, cmd_strobe}, 32'(1 << i));
            idle();
            check_eq("R4 strobe ends", {26'b0, cmd_strobe}, 32'h0);
        end
        drive(1'b1, A_CMD, 32'h3F, 8'h0);
        check_eq("R4 all strobes", {26'b0, cmd_strobe}, 32'h3F);
        // R5
        rd(A_CMD, rv); check_eq("R5 cmd reads zero", rv, 32'h0);
        idle();

        // R6 status
        eng_sts = 8'hC1; idle();
        rd(A_STS, rv); check_eq("R6 status follows", rv, 32'hC1);
        eng_sts = 8'h02; idle();
        eng_sts = 8'h00; idle();
        rd(A_STS, rv); check_eq("R6 overrun sticky", rv, 32'h02);
        // R7
        drive(1'b1, A_CMD, 32'h08, 8'h0);
        rd(A_STS, rv); check_eq("R7 clear overrun", rv, 32'h00);
        eng_sts = 8'h02;
        drive(1'b1, A_CMD, 32'h08, 8'h0);
        eng_sts = 8'h00;
        rd(A_STS, rv); check_eq("R7 set wins over clear", rv, 32'h02);
        drive(1'b1, A_CMD, 32'h08, 8'h0);
        rd(A_STS, rv); check_eq("R7 clear after", rv, 32'h00);

        // R8 enable gating
        drive(1'b0, A_FLG, 32'h0, 8'hFF);
        rd(A_FLG, rv); check_eq("R8 disabled events", rv, 32'h0);
        check_eq("R10 irq low", {31'b0, irq}, 32'h0);
        drive(1'b1, A_IEN, 32'h0F, 8'h0);
        drive(1'b0, A_FLG, 32'h0, 8'hFF);
        rd(A_FLG, rv); check_eq("R8 enabled subset", rv, 32'h0F);
        check_eq("R10 irq high", {31'b0, irq}, 32'h1);
        // R9
        drive(1'b1, A_FLG, 32'h05, 8'h0);
        rd(A_FLG, rv); check_eq("R9 w1c", rv, 32'h0A);
        drive(1'b1, A_FLG, 32'h00, 8'h0);
        rd(A_FLG, rv); check_eq("R9 write zero keeps", rv, 32'h0A);
        drive(1'b1, A_FLG, 32'h02, 8'h02);
        rd(A_FLG, rv); check_eq("R9 set wins", rv, 32'h0A);
        drive(1'b1, A_FLG, 32'hFF, 8'h0);
        rd(A_FLG, rv); check_eq("R9 clear all", rv, 32'h0);
        check_eq("R10 irq drops", {31'b0, irq}, 32'h0);

        // R11 error counts
        @(negedge clk); err_upd = 1'b1; err_tx_in = 8'h12; err_rx_in = 8'h34;
        @(negedge clk); err_upd = 1'b0;
        rd(A_ERR, rv); check_eq("R11 load", rv, 32'h00340012);
        drive(1'b1, A_ERR, 32'h1, 8'h0);
        rd(A_ERR, rv); check_eq("R11 nonzero write ignored", rv, 32'h00340012);
        drive(1'b1, A_ERR, 32'h0, 8'h0);
        rd(A_ERR, rv); check_eq("R11 zero clears", rv, 32'h0);

        // R12 read-only and unmapped
        eng_sts = 8'h24; idle();
        drive(1'b1, A_STS, 32'hFFFF_FFFF, 8'h0);
        rd(A_STS, rv); check_eq("R12 status write ignored", rv, 32'h24);
        drive(1'b1, 3'd6, 32'hFFFF_FFFF, 8'h0);
        rd(3'd6, rv); check_eq("R12 unmapped 6", rv, 32'h0);
        rd(3'd7, rv); check_eq("R12 unmapped 7", rv, 32'h0);
        rd(A_MODE, rv); check_eq("R12 mode untouched", rv, 32'h1E);
        rd(A_FLG, rv); check_eq("R12 flags untouched", rv, 32'h0);

        // random flag / enable traffic: R8 R9 R10
        m_flags = 8'h0; m_en = 8'h0F;
        for (int k = 0; k < 400; k++) begin
            int op;
            logic [7:0] d, e;
            op = int'($urandom % 4);
            d  = 8'($urandom);
            e  = 8'($urandom);
            case (op)
                0: begin drive(1'b1, A_IEN, {24'b0, d}, e);
                         m_flags = flag_next(m_flags, m_en, 8'h0, e); m_en = d; end
                1: begin drive(1'b1, A_FLG, {24'b0, d}, e);
                         m_flags = flag_next(m_flags, m_en, d, e); end
                2: begin drive(1'b0, A_FLG, 32'h0, e);
                         m_flags = flag_next(m_flags, m_en, 8'h0, e); end
                default: begin drive(1'b1, A_FLG, {24'b0, d}, 8'h0);
                         m_flags = flag_next(m_flags, m_en, d, 8'h0); end
            endcase
            rd(A_FLG, rv); check_eq("R8/R9 random flags", rv, {24'b0, m_flags});
            check_eq("R10 random irq", {31'b0, irq}, {31'b0, (m_flags != 8'h0)});
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule